// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Tracker

This block watches the command bus that a memory controller drives toward a four-bank DDR SDRAM. On every rising clock edge it decodes the command from chip select, RAS, CAS and WE. It keeps a record of which banks hold an open row, and which row that is. Per-bank and shared down-counters hold every minimum command spacing as a whole number of clocks. From these counters the block reports, for each bank, which commands the device would accept at the next edge.

A command that breaks the state rules raises a one-cycle illegal flag. A command that comes before its spacing has run out raises a one-cycle early flag. In both cases the tracker treats the command as never issued, so its state follows only the commands the device would act on. Address bit 10 selects auto-precharge on reads and writes, and selects precharge of all banks on a precharge command. The write auto-precharge recovery is built from the write-recovery and precharge times, given in picoseconds, with each one rounded up to whole clocks on its own. A row that stays open longer than the maximum active time sets a sticky violation flag.

Top module: `ddr_bank_timer`

## Requirements
- R1: The command is decoded from {ras_n,cas_n,we_n} while cs_n is low: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set. 111 and 110 have no effect. While cs_n is high the bus is ignored and no state or flag changes.
- R2: An accepted activate opens bank `ba` and stores `addr` as its row. bank_open[b] shows the bank is open, and open_row[b*AW +: AW] holds the row one cycle after the activate.
- R3: An activate to an open bank, a read or write to a closed bank, and a refresh or mode-register set while any bank is open are illegal. err_illegal goes high for the one cycle after the command, and the command changes no state.
- R4: A legal command that comes before one of its spacings has run out raises err_early for the one cycle after it and changes no state. When a command is both illegal and early, only err_illegal is raised.
- R5: To the same bank, read or write must come at least T_RCD edges after the activate, and a new activate at least T_RC edges after the previous one. Activates to different banks must be at least T_RRD edges apart.
- R6: Precharging an open bank needs at least T_RAS_MIN edges since its activate and at least BURST_CK+ceil(WR_PS/CK_PS) edges since its last write. An activate after a precharge needs at least ceil(RP_PS/CK_PS) edges.
- R7: A read to any bank must come at least BURST_CK+T_WTR edges after the last write.
- R8: A read or write with addr[10] high closes the bank. The next activate to that bank needs at least BURST_CK+ceil(RP_PS/CK_PS) edges after a read, and BURST_CK+ceil(WR_PS/CK_PS)+ceil(RP_PS/CK_PS) edges after a write.
- R9: A precharge with addr[10] high closes all banks whatever `ba` holds. With addr[10] low it closes only bank `ba`. A precharge of a closed bank changes nothing.
- R10: No command of any kind is accepted within T_MRD edges after a mode-register set. An activate needs at least T_RFC edges after a refresh.
- R11: ok_act, ok_rd, ok_wr and ok_pre (per bank) and ok_cfg (refresh or mode-register set) are high exactly when that command would be accepted at the next edge.
- R12: When a bank stays open for more than T_RAS_MAX edges after its activate, tras_viol goes high and stays high until reset.
- R13: After a synchronous reset all banks are closed, all flags are low, ok_act and ok_cfg are all high, and ok_rd and ok_wr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW (2) | Bank address |
| addr | input | AW (13) | Row on activate; bit 10 selects auto-precharge or all-bank precharge |
| bank_open | output | NB (4) | One bit per bank, set while a row is open |
| open_row | output | NB*AW (52) | Open row of each bank, bank b at bits b*AW +: AW |
| ok_act | output | NB | Activate to bank b would be accepted |
| ok_rd | output | NB | Read to bank b would be accepted |
| ok_wr | output | NB | Write to bank b would be accepted |
| ok_pre | output | NB | Single-bank precharge to bank b would be accepted |
| ok_cfg | output | 1 | Refresh or mode-register set would be accepted |
| err_illegal | output | 1 | One-cycle pulse after an illegal command |
| err_early | output | 1 | One-cycle pulse after a command issued too soon |
| tras_viol | output | 1 | Sticky: a row stayed open past its maximum active time |

## Verification
The hardest cases to reach are the ones where two spacings overlap on the same bank. After an auto-precharged write, the row-cycle time and the recovery time both run at once, and only a gap set between the two reveals which one the design obeys. The stimulus therefore sweeps each gap across its threshold, one cycle at a time, from a fresh reset. The earlier command is placed so that the spacing under test is the one that decides: for example, a read placed late enough that the row-cycle time has already run out. The recovery parameters are chosen so that rounding each term up on its own gives a different cycle count from rounding their sum. The maximum active time is set short so that expiry can be watched on the exact edge.

// File: rtl/ddrt_pkg.sv
package ddrt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_NOP;
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ddrt_global.sv
module ddrt_global #(
  parameter int CW      = 6,
  parameter int T_RRD   = 2,
  parameter int T_MRD   = 2,
  parameter int WTR_GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic act_i,
  input  logic wr_i,
  input  logic mrs_i,
  output logic rrd_ok_o,
  output logic mrd_ok_o,
  output logic wtr_ok_o
);

  logic [CW-1:0] rrd_q, mrd_q, wtr_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur, input logic [CW-1:0] ld);
    logic [CW-1:0] d;
    d = (cur == '0) ? cur : cur - CW'(1);
    return (d > ld) ? d : ld;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q <= '0;
      mrd_q <= '0;
      wtr_q <= '0;
    end else begin
      rrd_q <= step(rrd_q, act_i ? CW'(T_RRD - 1) : '0);
      mrd_q <= step(mrd_q, mrs_i ? CW'(T_MRD - 1) : '0);
      wtr_q <= step(wtr_q, wr_i  ? CW'(WTR_GAP - 1) : '0);
    end
  end

  assign rrd_ok_o = (rrd_q == '0);
  assign mrd_ok_o = (mrd_q == '0);
  assign wtr_ok_o = (wtr_q == '0);

  AST_MRD_QUIET: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (mrd_q == '0)); // R10

endmodule

// File: rtl/ddrt_bank.sv
module ddrt_bank #(
  parameter int AW         = 13,
  parameter int CW         = 6,
  parameter int LW         = 15,
  parameter int T_RCD      = 3,
  parameter int T_RC       = 11,
  parameter int T_RAS_MIN  = 9,
  parameter int T_RAS_MAX  = 24000,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 15,
  parameter int RD_AP_GAP  = 5,
  parameter int WR_AP_GAP  = 8,
  parameter int WR_PRE_GAP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          ap_i,
  input  logic          close_i,
  input  logic          ref_i,
  input  logic [AW-1:0] row_i,
  output logic          open_o,
  output logic [AW-1:0] row_o,
  output logic          act_ok_o,
  output logic          rw_ok_o,
  output logic          pre_ok_o,
  output logic          over_o
);

  logic          open_q;
  logic [AW-1:0] row_q;
  logic [CW-1:0] act_cnt, rw_cnt, pre_cnt;
  logic [CW-1:0] act_ld, rw_ld, pre_ld;
  logic [LW-1:0] life_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur, input logic [CW-1:0] ld);
    logic [CW-1:0] d;
    d = (cur == '0) ? cur : cur - CW'(1);
    return (d > ld) ? d : ld;
  endfunction

  always_comb begin
    act_ld = '0;
    rw_ld  = '0;
    pre_ld = '0;
    if (act_i) begin
      act_ld = CW'(T_RC - 1);
      rw_ld  = CW'(T_RCD - 1);
      pre_ld = CW'(T_RAS_MIN - 1);
    end
    if (rd_i && ap_i) act_ld = CW'(RD_AP_GAP - 1);
    if (wr_i) begin
      if (ap_i) act_ld = CW'(WR_AP_GAP - 1);
      else      pre_ld = CW'(WR_PRE_GAP - 1);
    end
    if (close_i && open_q) act_ld = CW'(T_RP - 1);
    if (ref_i)             act_ld = CW'(T_RFC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      row_q   <= '0;
      act_cnt <= '0;
      rw_cnt  <= '0;
      pre_cnt <= '0;
      life_q  <= '0;
    end else begin
      act_cnt <= step(act_cnt, act_ld);
      rw_cnt  <= step(rw_cnt, rw_ld);
      pre_cnt <= step(pre_cnt, pre_ld);
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        life_q <= '0;
      end else begin
        if (((rd_i || wr_i) && ap_i) || close_i) open_q <= 1'b0;
        if (open_q && life_q != LW'(T_RAS_MAX)) life_q <= life_q + LW'(1);
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = (act_cnt == '0);
  assign rw_ok_o  = (rw_cnt == '0);
  assign pre_ok_o = (pre_cnt == '0);
  assign over_o   = open_q && (life_q == LW'(T_RAS_MAX));

  AST_ACT_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    act_i |-> (!open_q && act_cnt == '0)); // R5
  AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
    (rd_i || wr_i) |-> (open_q && rw_cnt == '0)); // R3
  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    act_i |=> (open_q && row_q == $past(row_i))); // R2
  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && ap_i) |=> !open_q); // R8

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddrt_pkg::*;
#(
  parameter int NB        = 4,
  parameter int AW        = 13,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 11,
  parameter int T_RAS_MIN = 9,
  parameter int T_RAS_MAX = 24000,
  parameter int T_MRD     = 2,
  parameter int T_WTR     = 2,
  parameter int T_RFC     = 15,
  parameter int BURST_CK  = 2,
  parameter int CK_PS     = 5000,
  parameter int WR_PS     = 15000,
  parameter int RP_PS     = 15000,
  localparam int BAW      = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BAW-1:0]   ba,
  input  logic [AW-1:0]    addr,
  output logic [NB-1:0]    bank_open,
  output logic [NB*AW-1:0] open_row,
  output logic [NB-1:0]    ok_act,
  output logic [NB-1:0]    ok_rd,
  output logic [NB-1:0]    ok_wr,
  output logic [NB-1:0]    ok_pre,
  output logic             ok_cfg,
  output logic             err_illegal,
  output logic             err_early,
  output logic             tras_viol
);

  localparam int T_WR       = ceil_div(WR_PS, CK_PS);
  localparam int T_RP       = ceil_div(RP_PS, CK_PS);
  localparam int T_DAL      = T_WR + T_RP;
  localparam int RD_AP_GAP  = BURST_CK + T_RP;
  localparam int WR_AP_GAP  = BURST_CK + T_DAL;
  localparam int WR_PRE_GAP = BURST_CK + T_WR;
  localparam int WTR_GAP    = BURST_CK + T_WTR;
  localparam int CW = $clog2(T_RC + T_RFC + WR_AP_GAP + T_RAS_MIN + T_RRD + T_MRD + WTR_GAP + T_RCD + 1);
  localparam int LW = $clog2(T_RAS_MAX + 1);

  cmd_e          cmd;
  logic          ap, illegal, early, go;
  logic          any_open, all_act_ok, all_pre_ok;
  logic          rrd_ok, mrd_ok, wtr_ok;
  logic [NB-1:0] open_v, act_ok_v, rw_ok_v, pre_ok_v, over_v;
  logic [NB-1:0] act_s, rd_s, wr_s, close_s;
  logic [AW-1:0] row_v [NB];

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign ap  = addr[AP_BIT];

  always_comb begin
    any_open   = |open_v;
    all_act_ok = &act_ok_v;
    all_pre_ok = 1'b1;
    for (int b = 0; b < NB; b++)
      if (open_v[b] && !pre_ok_v[b]) all_pre_ok = 1'b0;
    illegal = 1'b0;
    early   = 1'b0;
    case (cmd)
      CMD_ACT: begin
        illegal = open_v[ba];
        early   = !(act_ok_v[ba] && rrd_ok && mrd_ok);
      end
      CMD_RD: begin
        illegal = !open_v[ba];
        early   = !(rw_ok_v[ba] && wtr_ok && mrd_ok);
      end
      CMD_WR: begin
        illegal = !open_v[ba];
        early   = !(rw_ok_v[ba] && mrd_ok);
      end
      CMD_PRE: early = !mrd_ok || (ap ? !all_pre_ok : (open_v[ba] && !pre_ok_v[ba]));
      CMD_REF, CMD_MRS: begin
        illegal = any_open;
        early   = !(all_act_ok && mrd_ok);
      end
      default: ;
    endcase
    if (illegal) early = 1'b0;
    go = (cmd != CMD_NOP) && !illegal && !early;
    for (int b = 0; b < NB; b++) begin
      act_s[b]   = go && cmd == CMD_ACT && int'(ba) == b;
      rd_s[b]    = go && cmd == CMD_RD  && int'(ba) == b;
      wr_s[b]    = go && cmd == CMD_WR  && int'(ba) == b;
      close_s[b] = go && cmd == CMD_PRE && (ap || int'(ba) == b);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ddrt_bank #(
      .AW(AW), .CW(CW), .LW(LW), .T_RCD(T_RCD), .T_RC(T_RC),
      .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP), .T_RFC(T_RFC),
      .RD_AP_GAP(RD_AP_GAP), .WR_AP_GAP(WR_AP_GAP), .WR_PRE_GAP(WR_PRE_GAP)
    ) i_bank (
      .clk(clk), .rst(rst),
      .act_i(act_s[g]), .rd_i(rd_s[g]), .wr_i(wr_s[g]), .ap_i(ap),
      .close_i(close_s[g]), .ref_i(go && cmd == CMD_REF), .row_i(addr),
      .open_o(open_v[g]), .row_o(row_v[g]), .act_ok_o(act_ok_v[g]),
      .rw_ok_o(rw_ok_v[g]), .pre_ok_o(pre_ok_v[g]), .over_o(over_v[g])
    );
    assign open_row[g*AW +: AW] = row_v[g];
    assign ok_act[g] = !open_v[g] && act_ok_v[g] && rrd_ok && mrd_ok;
    assign ok_rd[g]  = open_v[g] && rw_ok_v[g] && wtr_ok && mrd_ok;
    assign ok_wr[g]  = open_v[g] && rw_ok_v[g] && mrd_ok;
    assign ok_pre[g] = mrd_ok && (!open_v[g] || pre_ok_v[g]);
  end

  ddrt_global #(.CW(CW), .T_RRD(T_RRD), .T_MRD(T_MRD), .WTR_GAP(WTR_GAP)) i_global (
    .clk(clk), .rst(rst), .issue_i(go),
    .act_i(go && cmd == CMD_ACT), .wr_i(go && cmd == CMD_WR), .mrs_i(go && cmd == CMD_MRS),
    .rrd_ok_o(rrd_ok), .mrd_ok_o(mrd_ok), .wtr_ok_o(wtr_ok)
  );

  assign bank_open = open_v;
  assign ok_cfg    = !any_open && all_act_ok && mrd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_illegal <= 1'b0;
      err_early   <= 1'b0;
      tras_viol   <= 1'b0;
    end else begin
      err_illegal <= illegal;
      err_early   <= early;
      tras_viol   <= tras_viol | (|over_v);
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!err_illegal && !err_early)); // R1
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    tras_viol |=> tras_viol); // R12

endmodule

// File: tb/test_ddr_bank_timer.sv
module test_ddr_bank_timer;

  localparam int NB = 4, AW = 13;
  localparam int B_RCD = 3, B_RRD = 2, B_RC = 9, B_RASMIN = 5, B_RASMAX = 40;
  localparam int B_MRD = 2, B_WTR = 2, B_RFC = 10, B_BURST = 2;
  localparam int B_CK = 7500, B_WR = 16000, B_RP = 16000;
  localparam int E_WR  = (B_WR + B_CK - 1) / B_CK;
  localparam int E_RP  = (B_RP + B_CK - 1) / B_CK;
  localparam int E_DAL = E_WR + E_RP;

  localparam logic [2:0] C_NOP = 3'b111, C_BST = 3'b110, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;
  localparam int AP = 1 << 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bank_open, ok_act, ok_rd, ok_wr, ok_pre;
  logic [NB*AW-1:0] open_row;
  logic ok_cfg, err_illegal, err_early, tras_viol;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_bank_timer #(
    .T_RCD(B_RCD), .T_RRD(B_RRD), .T_RC(B_RC), .T_RAS_MIN(B_RASMIN), .T_RAS_MAX(B_RASMAX),
    .T_MRD(B_MRD), .T_WTR(B_WTR), .T_RFC(B_RFC), .BURST_CK(B_BURST),
    .CK_PS(B_CK), .WR_PS(B_WR), .RP_PS(B_RP)
  ) i_ddr_bank_timer (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .bank_open(bank_open), .open_row(open_row),
    .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr), .ok_pre(ok_pre), .ok_cfg(ok_cfg),
    .err_illegal(err_illegal), .err_early(err_early), .tras_viol(tras_viol)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] c, input logic csn, input int b, input int a);
    cs_n = csn; {ras_n, cas_n, we_n} = c; ba = 2'(b); addr = AW'(a);
  endtask

  task automatic cmd(input logic [2:0] c, input int b, input int a);
    @(negedge clk); put(c, 1'b0, b, a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); put(C_NOP, 1'b1, 0, 0);
    end
  endtask

  function automatic logic ok_of(input logic [2:0] c, input int b);
    case (c)
      C_ACT:   return ok_act[b];
      C_RD:    return ok_rd[b];
      C_WR:    return ok_wr[b];
      C_PRE:   return ok_pre[b];
      default: return ok_cfg;
    endcase
  endfunction

  // Issue the second command of a pair: check R11 beforehand, then the flags.
  task automatic tail(input string tag, input logic [2:0] c, input int b, input int a, input bit exp_early);
    @(negedge clk);
    check({tag, " R11 ok"}, ok_of(c, b), !exp_early);
    put(c, 1'b0, b, a);
    idle(1);
    check({tag, " R4 early"}, err_early, exp_early);
    check({tag, " R3 illegal"}, err_illegal, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); put(C_NOP, 1'b1, 0, 0); rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    do_reset();
    idle(1);
    // R13 reset state
    check("R13 open", bank_open, 0);
    check("R13 ok_act", ok_act, 4'hF);
    check("R13 ok_rd", ok_rd, 0);
    check("R13 ok_wr", ok_wr, 0);
    check("R13 ok_cfg", ok_cfg, 1);
    check("R13 flags", {err_illegal, err_early, tras_viol}, 0);

    // R2 activate opens bank and stores row
    cmd(C_ACT, 2, 13'h1ABC); idle(1);
    check("R2 open", bank_open, 4'b0100);
    check("R2 row", open_row[2*AW +: AW], 13'h1ABC);

    // R1 deselected activate and no-op codes are ignored
    do_reset();
    @(negedge clk); put(C_ACT, 1'b1, 0, 5);
    cmd(C_BST, 1, 0);
    cmd(C_NOP, 3, 0);
    idle(1);
    check("R1 open", bank_open, 0);
    check("R1 flags", {err_illegal, err_early}, 0);

    // R3 illegal commands and R4 precedence
    do_reset();
    cmd(C_RD, 1, 0); idle(1);
    check("R3 rd closed illegal", err_illegal, 1);
    check("R3 rd closed early", err_early, 0);
    idle(1);
    check("R3 one cycle", err_illegal, 0);
    cmd(C_ACT, 0, 13'h55); idle(1);
    cmd(C_ACT, 0, 13'h77); idle(1);
    check("R4 illegal wins", {err_illegal, err_early}, 2'b10);
    check("R3 row kept", open_row[0 +: AW], 13'h55);
    cmd(C_MRS, 0, 0); idle(1);
    check("R3 mrs open", err_illegal, 1);
    cmd(C_REF, 0, 0); idle(1);
    check("R3 ref open", err_illegal, 1);
    check("R3 state kept", bank_open, 4'b0001);

    // R5 tRCD sweep
    for (int g = 1; g <= 5; g++) begin
      do_reset(); cmd(C_ACT, 0, 1); idle(g - 1);
      tail("R5 rcd", C_RD, 0, 0, g < B_RCD);
    end
    // R5 tRRD sweep, early activate not applied (R4)
    for (int g = 1; g <= 4; g++) begin
      do_reset(); cmd(C_ACT, 0, 1); idle(g - 1);
      tail("R5 rrd", C_ACT, 1, 2, g < B_RRD);
      check("R4 not applied", bank_open[1], g >= B_RRD);
    end
    // R6 tRAS min sweep
    for (int g = 1; g <= 7; g++) begin
      do_reset(); cmd(C_ACT, 2, 1); idle(g - 1);
      tail("R6 rasmin", C_PRE, 2, 0, g < B_RASMIN);
      check("R6 pre closes", bank_open[2], g < B_RASMIN);
    end
    // R5/R6 tRC and tRP together
    for (int p = 5; p <= 7; p++)
      for (int g = 1; g <= 6; g++) begin
        do_reset(); cmd(C_ACT, 1, 1); idle(p - 1); cmd(C_PRE, 1, 0); idle(g - 1);
        tail("R6 rp/R5 rc", C_ACT, 1, 3, (g < E_RP) || (p + g < B_RC));
      end
    // R8 write auto-precharge, separate rounding
    for (int g = 1; g <= 9; g++) begin
      do_reset(); cmd(C_ACT, 3, 1); idle(B_RCD - 1); cmd(C_WR, 3, AP);
      if (g == 1) begin
        idle(1);
        check("R8 wr ap closes", bank_open[3], 0);
        tail("R8 wr ap", C_ACT, 3, 2, 1);
      end else begin
        idle(g - 1);
        tail("R8 wr ap", C_ACT, 3, 2, (g < B_BURST + E_DAL) || (B_RCD + g < B_RC));
      end
    end
    // R8 read auto-precharge
    for (int g = 1; g <= 7; g++) begin
      do_reset(); cmd(C_ACT, 0, 1); idle(5); cmd(C_RD, 0, AP); idle(g - 1);
      tail("R8 rd ap", C_ACT, 0, 2, (g < B_BURST + E_RP) || (6 + g < B_RC));
    end
    // R6 write recovery before precharge
    for (int g = 1; g <= 7; g++) begin
      do_reset(); cmd(C_ACT, 0, 1); idle(B_RCD - 1); cmd(C_WR, 0, 0); idle(g - 1);
      tail("R6 wr", C_PRE, 0, 0, (g < B_BURST + E_WR) || (B_RCD + g < B_RASMIN));
    end
    // R7 write to read, other bank
    for (int g = 1; g <= 5; g++) begin
      do_reset(); cmd(C_ACT, 0, 1); idle(1); cmd(C_ACT, 1, 1); idle(2);
      cmd(C_WR, 0, 0); idle(g - 1);
      tail("R7 wtr", C_RD, 1, 0, g < B_BURST + B_WTR);
    end
    // R10 mode register and refresh spacing
    for (int g = 1; g <= 3; g++) begin
      do_reset(); cmd(C_MRS, 0, 0); idle(g - 1);
      tail("R10 mrd", C_ACT, 0, 1, g < B_MRD);
    end
    for (int g = 1; g <= 12; g++) begin
      do_reset(); cmd(C_REF, 0, 0); idle(g - 1);
      tail("R10 rfc", C_ACT, 2, 1, g < B_RFC);
    end

    // R9 single and all-bank precharge
    do_reset();
    cmd(C_ACT, 0, 1); idle(1); cmd(C_ACT, 1, 1); idle(1);
    cmd(C_ACT, 2, 1); idle(1); cmd(C_ACT, 3, 1); idle(5);
    cmd(C_PRE, 2, 0); idle(1);
    check("R9 single", bank_open, 4'b1011);
    cmd(C_PRE, 2, 0); idle(1);
    check("R9 closed bank flags", {err_illegal, err_early}, 0);
    check("R9 closed bank state", bank_open, 4'b1011);
    cmd(C_PRE, 0, AP); idle(1);
    check("R9 all", bank_open, 0);

    // R12 maximum active time
    do_reset();
    cmd(C_ACT, 1, 1); idle(B_RASMAX + 1);
    check("R12 at limit", tras_viol, 0);
    idle(1);
    check("R12 past limit", tras_viol, 1);
    cmd(C_PRE, 1, 0); idle(3);
    check("R12 sticky", tras_viol, 1);
    do_reset();
    cmd(C_ACT, 1, 1); idle(B_RASMAX - 1); cmd(C_PRE, 1, 0); idle(3);
    check("R12 closed in time", tras_viol, 0);

    done = 1'b1;
    report();
  end

endmodule